// File: doc/BRIEF.md
# DS3 Receive Overhead Bit Output Port

This block sits behind a DS3 receive framer. From the serial receive stream it takes the one overhead bit at the head of each 85-bit block and nothing else. It presents that bit on a serial output and holds it there for the full 85-clock block. The framer supplies a one-cycle frame-start pulse that marks the first bit of a DS3 frame. A frame is 4760 bits long: 7 subframes of 8 blocks, which gives 56 overhead bits per frame. The bits leave in frame order: X, F1, C, F0 and so on.

Terminal logic can capture the bit in either of two ways. It can latch `oh_bit` on the falling clock edge while the single-cycle strobe `oh_strobe` is high. The strobe sits at the middle of the hold interval. Terminal logic that prefers a dedicated clock can instead use `oh_clk`, a registered square wave at the overhead rate, and sample on its rising edge. That edge falls at mid-bit as well. `oh_frame_mark` marks the first overhead bit of each frame, so the receiver can align the sequence. All outputs are registered, and no clock gating is used.

Top module: `ds3_oh_port`

## Requirements
- R1: The cycle after the design samples the frame bit at position 85*n (n = 0..55, position 0 being the bit that arrives with `frame_start`), `oh_bit` takes that bit and holds it for 85 cycles. Payload bits never reach `oh_bit`.
- R2: Counting k = 0 as the first cycle in which a new `oh_bit` value is shown, `oh_strobe` is high for exactly one cycle per overhead bit, at k = 42.
- R3: `oh_bit` does not change between the cycle before the strobe and the strobe cycle. It changes only at k = 0.
- R4: `oh_frame_mark` is 1 during the whole 85-cycle hold of overhead index 0 (the first X bit) and 0 during the holds of every other index.
- R5: `oh_clk` is 0 for k = 0..41 and 1 for k = 42..84, so its rising edge coincides with the strobe.
- R6: While `rst` is high (synchronous, active-high), all outputs are 0 after the next clock edge.
- R7: Until the first `frame_start` after reset, all outputs stay 0 whatever `rx_data` carries.
- R8: A `frame_start` at any point, including the middle of a block, restarts the bit count. The bit sampled with it becomes overhead index 0.
- R9: With no further `frame_start`, the block keeps running. After index 55 it returns to index 0 on the following 85-bit boundary, and the frame mark reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive line clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 1 | Serial DS3 receive data |
| frame_start | input | 1 | One-cycle pulse with the first bit of a frame |
| oh_bit | output | 1 | Current overhead bit, held one block |
| oh_strobe | output | 1 | One-cycle mid-bit sampling enable |
| oh_frame_mark | output | 1 | High while overhead index 0 is held |
| oh_clk | output | 1 | Overhead-rate square wave, rising mid-bit |

## Verification
The hardest state to reach from the ports is the free-running wrap from index 55 back to 0 with no new frame-start pulse. A re-alignment that lands in the middle of a block is equally hard. The stimulus runs two full frames on a single pulse and then fires `frame_start` at an irregular offset. Directed frames that set payload and overhead bits to opposite values show that payload never leaks onto the output. Random data fills the remaining stretches, and every output is compared each cycle against a bench model of the frame position.

// File: rtl/ds3_oh_pkg.sv
package ds3_oh_pkg;

  // Output word produced by the capture stage
  typedef struct packed {
    logic bit_val;
    logic mark;
  } oh_word_t;

  // Next value of a wrapping counter
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v == last) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/ds3_oh_pos_cnt.sv
module ds3_oh_pos_cnt #(
  parameter int BLOCK_BITS   = 85,
  parameter int OH_PER_FRAME = 56,
  localparam int PW = $clog2(BLOCK_BITS),
  localparam int IW = $clog2(OH_PER_FRAME)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  output logic          active,
  output logic [PW-1:0] eff_pos,
  output logic [IW-1:0] eff_idx
);
  import ds3_oh_pkg::*;

  localparam logic [PW-1:0] POS_LAST = PW'(BLOCK_BITS - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(OH_PER_FRAME - 1);

  logic          locked_q;
  logic [PW-1:0] pos_q;
  logic [IW-1:0] idx_q;

  // A frame-start pulse overrides the running position in its own cycle
  always_comb begin
    active  = locked_q | frame_start;
    eff_pos = frame_start ? '0 : pos_q;
    eff_idx = frame_start ? '0 : idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      pos_q    <= '0;
      idx_q    <= '0;
    end else if (active) begin
      locked_q <= 1'b1;
      pos_q    <= PW'(wrap_inc(int'(eff_pos), int'(POS_LAST)));
      if (eff_pos == POS_LAST)
        idx_q <= IW'(wrap_inc(int'(eff_idx), int'(IDX_LAST)));
      else
        idx_q <= eff_idx;
    end
  end

endmodule

// File: rtl/ds3_oh_capture.sv
module ds3_oh_capture (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 at_head,
  input  logic                 first_idx,
  input  logic                 rx_data,
  output ds3_oh_pkg::oh_word_t word
);
  import ds3_oh_pkg::*;

  oh_word_t word_q;

  // Load only at the head of a block; hold for the rest of it
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (active && at_head) begin
      word_q.bit_val <= rx_data;
      word_q.mark    <= first_idx;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/ds3_oh_timing.sv
module ds3_oh_timing #(
  parameter int BLOCK_BITS = 85,
  parameter int STROBE_POS = 42,
  parameter bit OH_CLK_EN  = 1'b1,
  localparam int PW = $clog2(BLOCK_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [PW-1:0] eff_pos,
  output logic          strobe,
  output logic          oh_clk
);
  localparam logic [PW-1:0] MID = PW'(STROBE_POS);

  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= active && (eff_pos == MID);
  end
  assign strobe = strobe_q;

  // The overhead clock is a plain register, never a gated clock
  generate
    if (OH_CLK_EN) begin : g_ohclk
      logic clk_q;
      always_ff @(posedge clk) begin
        if (rst) clk_q <= 1'b0;
        else     clk_q <= active && (eff_pos >= MID);
      end
      assign oh_clk = clk_q;
    end else begin : g_no_ohclk
      assign oh_clk = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/ds3_oh_port.sv
module ds3_oh_port #(
  parameter int BLOCK_BITS     = 85,
  parameter int BLOCKS_PER_SUB = 8,
  parameter int SUBFRAMES      = 7,
  parameter bit OH_CLK_EN      = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_data,
  input  logic frame_start,
  output logic oh_bit,
  output logic oh_strobe,
  output logic oh_frame_mark,
  output logic oh_clk
);
  import ds3_oh_pkg::*;

  localparam int OH_PER_FRAME = BLOCKS_PER_SUB * SUBFRAMES;
  localparam int STROBE_POS   = BLOCK_BITS / 2;
  localparam int PW           = $clog2(BLOCK_BITS);
  localparam int IW           = $clog2(OH_PER_FRAME);

  logic          active;
  logic [PW-1:0] eff_pos;
  logic [IW-1:0] eff_idx;
  oh_word_t      word;

  ds3_oh_pos_cnt #(
    .BLOCK_BITS  (BLOCK_BITS),
    .OH_PER_FRAME(OH_PER_FRAME)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .active     (active),
    .eff_pos    (eff_pos),
    .eff_idx    (eff_idx)
  );

  ds3_oh_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .at_head  (eff_pos == '0),
    .first_idx(eff_idx == '0),
    .rx_data  (rx_data),
    .word     (word)
  );

  ds3_oh_timing #(
    .BLOCK_BITS(BLOCK_BITS),
    .STROBE_POS(STROBE_POS),
    .OH_CLK_EN (OH_CLK_EN)
  ) u_tim (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .eff_pos(eff_pos),
    .strobe (oh_strobe),
    .oh_clk (oh_clk)
  );

  assign oh_bit        = word.bit_val;
  assign oh_frame_mark = word.mark;

endmodule

// File: rtl/ds3_oh_port_chk.sv
module ds3_oh_port_chk (
  input logic clk,
  input logic rst,
  input logic oh_bit,
  input logic oh_strobe,
  input logic oh_frame_mark,
  input logic oh_clk
);

  // R2: the enable lasts a single cycle
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    oh_strobe |=> !oh_strobe);

  // R3: data is steady across the cycle before the strobe
  assert_bit_stable_R3: assert property (@(posedge clk) disable iff (rst)
    oh_strobe |-> $stable(oh_bit));

  // R5: the overhead clock rises only together with the strobe
  assert_clk_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(oh_clk) |-> oh_strobe);

  // R4: the frame mark moves only at a bit boundary, while the clock is low
  assert_mark_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(oh_frame_mark) |-> (!oh_clk && !oh_strobe));

  // R1: the data bit changes only at a bit boundary
  assert_bit_edge_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(oh_bit) |-> (!oh_clk && !oh_strobe));

endmodule

bind ds3_oh_port ds3_oh_port_chk i_chk (.*);

// File: tb/test_ds3_oh_port.sv
module test_ds3_oh_port;
  localparam int CLK_PERIOD = 10;
  localparam int BLK  = 85;
  localparam int MIDP = 42;
  localparam int NOH  = 56;
  localparam int FRM  = BLK * NOH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_data = 1'b0;
  logic frame_start = 1'b0;
  logic oh_bit, oh_strobe, oh_frame_mark, oh_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  bit m_locked = 1'b0;
  int m_pos = 0, m_idx = 0;
  logic e_bit = 1'b0, e_str = 1'b0, e_mark = 1'b0, e_clk = 1'b0;
  string phase = "R6 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  ds3_oh_port i_ds3_oh_port (
    .clk(clk), .rst(rst), .rx_data(rx_data), .frame_start(frame_start),
    .oh_bit(oh_bit), .oh_strobe(oh_strobe), .oh_frame_mark(oh_frame_mark), .oh_clk(oh_clk)
  );

  function automatic int next_pos(input int p);
    return (p == BLK - 1) ? 0 : p + 1;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%b expected=%b t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 oh_bit", oh_bit, e_bit);
    chk("R2 oh_strobe", oh_strobe, e_str);
    chk("R4 oh_frame_mark", oh_frame_mark, e_mark);
    chk("R5 oh_clk", oh_clk, e_clk);
  endtask

  task automatic model(input logic fs, input logic d);
    bit act;
    int ep, ei;
    act = m_locked || fs;
    ep  = fs ? 0 : m_pos;
    ei  = fs ? 0 : m_idx;
    if (act) begin
      if (ep == 0) begin
        e_bit  = d;
        e_mark = (ei == 0);
      end
      e_str = (ep == MIDP);
      e_clk = (ep >= MIDP);
      m_pos = next_pos(ep);
      m_idx = (ep == BLK - 1) ? ((ei == NOH - 1) ? 0 : ei + 1) : ei;
      m_locked = 1'b1;
    end else begin
      e_str = 1'b0;
      e_clk = 1'b0;
    end
  endtask

  task automatic step(input logic fs, input logic d);
    frame_start = fs;
    rx_data     = d;
    @(posedge clk);
    model(fs, d);
    @(negedge clk);
    compare_all();
  endtask

  // mode 0: random; 1: overhead 1 / payload 0; 2: overhead 0 / payload 1
  task automatic run(input int n, input bit fs_first, input int mode);
    for (int i = 0; i < n; i++) begin
      logic d;
      bit fs;
      fs = fs_first && (i == 0);
      if (mode == 0) d = 1'($urandom);
      else if ((fs ? 0 : m_pos) == 0) d = (mode == 1);
      else d = (mode == 2);
      step(fs, d);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: outputs cleared by reset
    chk("R6 oh_bit", oh_bit, 1'b0);
    chk("R6 oh_strobe", oh_strobe, 1'b0);
    chk("R6 oh_frame_mark", oh_frame_mark, 1'b0);
    chk("R6 oh_clk", oh_clk, 1'b0);
    rst = 1'b0;

    phase = "R7 before first frame";
    run(300, 1'b0, 0);

    phase = "R1 R4 R9 two frames, one pulse, random";
    run(2 * FRM + 200, 1'b1, 0);

    phase = "R8 mid-block realign";
    for (int i = 0; i < 37; i++) step(1'b0, 1'(~m_pos[0]));
    run(3000, 1'b1, 0);

    phase = "R1 payload zero, overhead one";
    run(FRM, 1'b1, 1);

    phase = "R1 R3 payload one, overhead zero";
    run(FRM, 1'b1, 2);

    phase = "R2 R5 random tail";
    run(500, 1'b1, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule